// File: doc/BRIEF.md
# Latched Change-Detect Interrupt Controller

This block watches a vector of status inputs, such as per-channel detector bits, and a set of per-channel strobes that pulse when a channel's transmit data changes. It raises an active-low interrupt when an unmasked status bit toggles in either direction, or when a strobe arrives on a channel whose arm bit is set. The status is held in a real-time data register. When an interrupt is raised, the unmasked bits of that register freeze until the host clears the interrupt. Masked bits keep following their inputs.

The host uses a simple register port with three locations: the data register, the mask register and a configuration word. Reading the data register returns the frozen snapshot and clears the interrupt. If the inputs have moved away from the snapshot by then, a new interrupt is raised at once and the new values are captured. The host must therefore treat the line as level-sensitive.

Writing the mask register also clears the interrupt. A configuration bit selects between two output modes. In driven mode the output is always enabled. In open-drain mode it is enabled only while it pulls low.

Top module: `irqc_top`

## Requirements
- R1: An unmasked status bit that changes from low to high or from high to low drives `irq_n_o` low. This happens at the third rising clock edge after the input changes: two synchroniser stages, then one detect stage.
- R2: A status bit whose mask bit is 1 never causes an interrupt. Its bit in the data register (address 0) follows the synchronised input, even while an interrupt is pending.
- R3: A pulse on `tx_chg_i[c]` drives `irq_n_o` low at the next rising edge, but only when arm bit c is set. The arm bits sit at bits [NCH:1] of the configuration word (address 2). With arm bit c clear, the pulse has no effect.
- R4: While an interrupt is pending, the unmasked bits of the data register hold their captured values and do not follow their inputs.
- R5: A read of address 0 returns the data register as it stands before the read edge. It clears the interrupt when no unmasked input differs from its captured bit and no armed strobe is present.
- R6: When a read of address 0 finds an unmasked input that differs from its captured bit, the interrupt stays asserted and the register captures the new values.
- R7: A write to address 1 loads the mask register and clears any pending interrupt. The data register is reloaded with the current inputs, so the write does not raise a new interrupt.
- R8: Bit 0 of the configuration word selects the output mode: 1 for driven, 0 for open drain. In driven mode `irq_oe_o` is always 1. In open-drain mode `irq_oe_o` is 1 exactly while `irq_n_o` is low.
- R9: After reset no interrupt is pending, the mask reads as all ones, and the configuration word reads as 0 (open drain, no channel armed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| status_i | input | NSTAT | Asynchronous status inputs |
| tx_chg_i | input | NCH | Per-channel transmit-change strobes, one cycle wide, synchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; a read of address 0 clears the interrupt |
| reg_addr_i | input | 2 | Register select: 0 data, 1 mask, 2 configuration |
| reg_wdata_i | input | NSTAT | Write data |
| reg_rdata_o | output | NSTAT | Read data, combinational from the current address |
| irq_n_o | output | 1 | Interrupt, active low |
| irq_oe_o | output | 1 | Output enable for the interrupt pin |

## Verification
The assertions assume that the transmit strobes are synchronous to `clk`. They also assume that a read and a write never occur in the same cycle, and that the mask changes only through the register port. The bench meets these conditions as follows:
- It changes status inputs and strobes only on falling edges.
- It keeps each strobe to a single cycle.
- It issues register accesses one at a time, each one cycle long.
- It waits at least three cycles after a status change before it expects an effect.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CFG  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Clear requests sent from the register port to the capture logic
    typedef struct packed {
        logic by_read;
        logic by_mask_wr;
    } clr_req_t;

    localparam int SYNC_STAGES = 2;

    function automatic logic sel_hit(input logic strobe, input logic [1:0] addr,
                                     input reg_sel_e which);
        return strobe && (reg_sel_e'(addr) == which);
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d_i;
                else             stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_core.sv
module irqc_core
    import irqc_pkg::*;
#(
    parameter int NSTAT = 8,
    parameter int NCH   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSTAT-1:0] st_i,
    input  logic [NCH-1:0]   tx_chg_i,
    input  logic [NCH-1:0]   arm_i,
    input  logic [NSTAT-1:0] mask_i,
    input  clr_req_t         clr_i,
    output logic             pend_o,
    output logic [NSTAT-1:0] snap_o
);
    logic [NSTAT-1:0] snap_q;
    logic [NSTAT-1:0] diff;
    logic             tx_hit;
    logic             trig;
    logic             pend_q;

    assign diff   = (st_i ^ snap_q) & ~mask_i;
    assign tx_hit = |(tx_chg_i & arm_i);
    assign trig   = (|diff) || tx_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            snap_q <= '0;
        end else if (clr_i.by_mask_wr) begin
            pend_q <= 1'b0;
            snap_q <= st_i;
        end else if (pend_q && !clr_i.by_read) begin
            snap_q <= (snap_q & ~mask_i) | (st_i & mask_i);
        end else begin
            pend_q <= trig;
            snap_q <= st_i;
        end
    end

    assign pend_o = pend_q;
    assign snap_o = snap_q;

    // R4
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr_i.by_read && !clr_i.by_mask_wr) |=> (pend_q && $stable(snap_q & ~mask_i)));

    // R6
    refire_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && clr_i.by_read && !clr_i.by_mask_wr && (|diff)) |=> pend_q);

    // R5
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i.by_read && !clr_i.by_mask_wr && !trig) |=> !pend_q);

    // R7
    mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i.by_mask_wr |=> !pend_q);
endmodule

// File: rtl/irqc_drv.sv
module irqc_drv (
    input  logic clk,
    input  logic rst,
    input  logic pend_i,
    input  logic drive_i,
    output logic irq_n_o,
    output logic irq_oe_o
);
    assign irq_n_o  = ~pend_i;
    assign irq_oe_o = drive_i | pend_i;

    // R8
    low_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_n_o |-> irq_oe_o);

    // R8
    od_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!drive_i && irq_n_o) |-> !irq_oe_o);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NSTAT = 8,
    parameter int NCH   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSTAT-1:0] status_i,
    input  logic [NCH-1:0]   tx_chg_i,
    input  logic             reg_wr_i,
    input  logic             reg_rd_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [NSTAT-1:0] reg_wdata_i,
    output logic [NSTAT-1:0] reg_rdata_o,
    output logic             irq_n_o,
    output logic             irq_oe_o
);
    localparam int CFG_W = NCH + 1;

    logic [NSTAT-1:0] st_sync;
    logic [NSTAT-1:0] mask_q;
    logic [NCH-1:0]   arm_q;
    logic             drive_q;
    logic [NSTAT-1:0] snap;
    logic             pend;
    clr_req_t         clr;
    logic [CFG_W-1:0] cfg_word;

    irqc_sync #(.W(NSTAT), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (status_i),
        .q_o (st_sync)
    );

    assign clr.by_read    = sel_hit(reg_rd_i, reg_addr_i, SEL_DATA);
    assign clr.by_mask_wr = sel_hit(reg_wr_i, reg_addr_i, SEL_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '1;
            arm_q   <= '0;
            drive_q <= 1'b0;
        end else begin
            if (clr.by_mask_wr) mask_q <= reg_wdata_i;
            if (sel_hit(reg_wr_i, reg_addr_i, SEL_CFG)) begin
                drive_q <= reg_wdata_i[0];
                arm_q   <= reg_wdata_i[NCH:1];
            end
        end
    end

    irqc_core #(.NSTAT(NSTAT), .NCH(NCH)) u_core (
        .clk      (clk),
        .rst      (rst),
        .st_i     (st_sync),
        .tx_chg_i (tx_chg_i),
        .arm_i    (arm_q),
        .mask_i   (mask_q),
        .clr_i    (clr),
        .pend_o   (pend),
        .snap_o   (snap)
    );

    irqc_drv u_drv (
        .clk      (clk),
        .rst      (rst),
        .pend_i   (pend),
        .drive_i  (drive_q),
        .irq_n_o  (irq_n_o),
        .irq_oe_o (irq_oe_o)
    );

    assign cfg_word = {arm_q, drive_q};

    always_comb begin
        case (reg_sel_e'(reg_addr_i))
            SEL_DATA: reg_rdata_o = snap;
            SEL_MASK: reg_rdata_o = mask_q;
            SEL_CFG:  reg_rdata_o = NSTAT'(cfg_word);
            default:  reg_rdata_o = '0;
        endcase
    end
endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
    localparam int NSTAT = 8;
    localparam int NCH   = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NSTAT-1:0] status = '0;
    logic [NCH-1:0]   tx_chg = '0;
    logic             reg_wr = 1'b0;
    logic             reg_rd = 1'b0;
    logic [1:0]       reg_addr = 2'd3;
    logic [NSTAT-1:0] reg_wdata = '0;
    logic [NSTAT-1:0] reg_rdata;
    logic             irq_n;
    logic             irq_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int         kind_q [$];
    logic [7:0] exp_q  [$];
    string      req_q  [$];
    event       mon_ev;

    always #10 clk = ~clk;

    irqc_top #(.NSTAT(NSTAT), .NCH(NCH)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .status_i    (status),
        .tx_chg_i    (tx_chg),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_n_o     (irq_n),
        .irq_oe_o    (irq_oe)
    );

    // Monitor: pops expected items and compares them with the ports
    initial begin
        forever begin
            @(mon_ev);
            while (kind_q.size() > 0) begin
                int         k;
                logic [7:0] e;
                logic [7:0] a;
                string      r;
                k = kind_q.pop_front();
                e = exp_q.pop_front();
                r = req_q.pop_front();
                case (k)
                    0:       a = {7'b0, irq_n};
                    1:       a = {7'b0, irq_oe};
                    default: a = reg_rdata;
                endcase
                n_tests++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", r, k, a, e);
                end
            end
        end
    end

    // Driver side: pushes an expected item and wakes the monitor
    task automatic expect_val(input int kind, input logic [7:0] e, input string r);
        kind_q.push_back(kind);
        exp_q.push_back(e);
        req_q.push_back(r);
        ->mon_ev;
        #1;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic rd_reg(input logic [1:0] a, input logic [7:0] e, input string r);
        reg_addr = a; reg_rd = 1'b1;
        expect_val(2, e, r);
        @(negedge clk);
        reg_rd = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic set_status(input logic [7:0] v);
        status = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_tx(input logic [3:0] v);
        tx_chg = v;
        @(negedge clk);
        tx_chg = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        expect_val(0, 8'h01, "R9 irq idle");
        expect_val(1, 8'h00, "R9 open drain released");
        rd_reg(2'd1, 8'hFF, "R9 mask all ones");
        rd_reg(2'd2, 8'h00, "R9 cfg zero");

        // R2: fully masked change is tracked, no interrupt
        set_status(8'h05);
        expect_val(0, 8'h01, "R2 masked no irq");
        rd_reg(2'd0, 8'h05, "R2 masked tracks");

        // R7: unmask; R1 falling change on bit0
        wr_reg(2'd1, 8'h00);
        expect_val(0, 8'h01, "R7 mask write no irq");
        set_status(8'h04);
        expect_val(0, 8'h00, "R1 falling change irq");
        expect_val(1, 8'h01, "R8 od enabled while low");

        // R4 frozen, R6 refire, R5 clear
        set_status(8'h06);
        expect_val(0, 8'h00, "R4 still pending");
        rd_reg(2'd0, 8'h04, "R4 snapshot frozen");
        expect_val(0, 8'h00, "R6 refire after read");
        rd_reg(2'd0, 8'h06, "R6 new value captured");
        expect_val(0, 8'h01, "R5 read clears");
        expect_val(1, 8'h00, "R8 od released");

        // R1 rising/falling on another bit
        set_status(8'h02);
        expect_val(0, 8'h00, "R1 bit2 fall irq");
        rd_reg(2'd0, 8'h02, "R5 read snapshot");
        expect_val(0, 8'h01, "R5 cleared");

        // R3: transmit strobes
        pulse_tx(4'b0001);
        expect_val(0, 8'h01, "R3 unarmed ignored");
        wr_reg(2'd2, 8'h02);
        pulse_tx(4'b0010);
        expect_val(0, 8'h01, "R3 other channel ignored");
        pulse_tx(4'b0001);
        expect_val(0, 8'h00, "R3 armed strobe irq");
        rd_reg(2'd0, 8'h02, "R3 read data");
        expect_val(0, 8'h01, "R5 cleared after tx");

        // R2 partial mask while pending
        wr_reg(2'd1, 8'h80);
        set_status(8'h82);
        expect_val(0, 8'h01, "R2 masked bit7 no irq");
        set_status(8'h83);
        expect_val(0, 8'h00, "R1 bit0 rise irq");
        set_status(8'h03);
        rd_reg(2'd0, 8'h03, "R2 masked live while pending");
        expect_val(0, 8'h01, "R5 cleared no diff");

        // R7: mask write clears pending
        set_status(8'h01);
        expect_val(0, 8'h00, "R1 bit1 fall irq");
        wr_reg(2'd1, 8'h00);
        expect_val(0, 8'h01, "R7 mask write clears");
        repeat (3) @(negedge clk);
        expect_val(0, 8'h01, "R7 no refire after mask write");

        // R8: driven mode
        wr_reg(2'd2, 8'h01);
        expect_val(1, 8'h01, "R8 driven mode enabled");
        rd_reg(2'd2, 8'h01, "R8 cfg readback");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule